// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits in front of the two ALU operand inputs of a five-stage in-order pipeline. For each operand it compares the source register index held by the instruction now in the execute stage against the destination indices of the two older instructions still in flight: one in the memory stage and one in the writeback stage. When an older instruction will write the register that the execute stage is about to read, the block steers that newer result to the ALU in place of the stale register-file value.

The decision is purely combinational. A producer counts only when its write enable is set and its destination is not the hard-wired zero register. When both in-flight instructions target the same source, the one in the memory stage wins because it is younger. The two operand paths are evaluated independently. The block drives the two 2-bit steering codes and also the two selected operand values, so a pipeline can use either form.

Top module: `opbyp_top`

## Requirements
- R1: With no qualifying producer match, a select is 2'b00 and its operand output equals the register-file value read for that source.
- R2: When the memory-stage write enable is 1 and its destination index equals a source index (not zero), that select is 2'b10 and the operand equals the memory-stage result.
- R3: When only the writeback stage qualifies for a source (write enable 1, matching non-zero destination), that select is 2'b01 and the operand equals the writeback result.
- R4: When both stages qualify for the same source, the select is 2'b10 and the memory-stage result is used.
- R5: A stage whose write enable is 0 never causes forwarding, even when its destination index matches.
- R6: A destination index of 0 never causes forwarding, even with write enable 1 and a source index of 0.
- R7: Operand A (first source) and operand B (second source) are decided independently; each can take a different source in the same evaluation.
- R8: A select never takes the value 2'b11.
- R9: Outputs follow input changes without any clock edge; the block holds no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src1_idx | input | REG_IDX_W | First source register index of the execute-stage instruction |
| ex_src2_idx | input | REG_IDX_W | Second source register index of the execute-stage instruction |
| ex_src1_val | input | DATA_W | Register-file value read for the first source |
| ex_src2_val | input | DATA_W | Register-file value read for the second source |
| mem_dst_idx | input | REG_IDX_W | Destination index of the memory-stage instruction |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_result | input | DATA_W | Result held in the memory stage |
| wb_dst_idx | input | REG_IDX_W | Destination index of the writeback-stage instruction |
| wb_wr_en | input | 1 | Writeback-stage instruction writes a register |
| wb_result | input | DATA_W | Result held in the writeback stage |
| sel_a | output | 2 | Steering code for operand A: 00 register file, 10 memory stage, 01 writeback |
| sel_b | output | 2 | Steering code for operand B, same encoding |
| alu_in_a | output | DATA_W | Selected value for operand A |
| alu_in_b | output | DATA_W | Selected value for operand B |

## Verification
The hardest case to reach is the one where both in-flight stages name the same register and only the priority rule decides the outcome, especially combined with the zero register or a cleared write enable on the younger stage, where the older stage must then take over. Directed tasks set both destination indices equal to a source and then clear the memory-stage enable or move its destination to zero, so the expected outcome moves from 2'b10 to 2'b01 and then to 2'b00. A sweep over small index values with both enables toggled covers the mixed cases in which A and B receive different sources.

// File: rtl/opbyp_pkg.sv
package opbyp_pkg;

   // Operand steering code; bit 1 = younger (memory) stage, bit 0 = older (writeback) stage
   typedef enum logic [1:0] {
      BYP_RF  = 2'b00,
      BYP_WB  = 2'b01,
      BYP_MEM = 2'b10
   } byp_sel_e;

   localparam int unsigned NUM_OPERANDS = 2;
   localparam int unsigned NUM_PRODUCERS = 2;

endpackage

// File: rtl/opbyp_match.sv
// Decides whether one producing stage supplies one source operand.
module opbyp_match #(
   parameter int unsigned REG_IDX_W  = 5,
   parameter bit          ZERO_GUARD = 1'b1
) (
   input  logic [REG_IDX_W-1:0] src_idx,
   input  logic [REG_IDX_W-1:0] dst_idx,
   input  logic                 wr_en,
   output logic                 hit
);

   logic idx_equal;
   logic dst_valid;

   assign idx_equal = (src_idx == dst_idx);

   generate
      if (ZERO_GUARD) begin : g_zero_guard
         assign dst_valid = wr_en && (dst_idx != '0);
      end else begin : g_no_guard
         assign dst_valid = wr_en;
      end
   endgenerate

   assign hit = idx_equal && dst_valid;

endmodule

// File: rtl/opbyp_prio.sv
// Turns the per-stage hit flags of one operand into a steering code.
module opbyp_prio
   import opbyp_pkg::*;
(
   input  logic     hit_mem,
   input  logic     hit_wb,
   output byp_sel_e sel
);

   always_comb begin
      if (hit_mem) begin
         sel = BYP_MEM;
      end else if (hit_wb) begin
         sel = BYP_WB;
      end else begin
         sel = BYP_RF;
      end
   end

endmodule

// File: rtl/opbyp_mux.sv
// Three-way operand data selector driven by the steering code.
module opbyp_mux
   import opbyp_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  byp_sel_e          sel,
   input  logic [DATA_W-1:0] rf_val,
   input  logic [DATA_W-1:0] mem_val,
   input  logic [DATA_W-1:0] wb_val,
   output logic [DATA_W-1:0] out_val
);

   always_comb begin
      unique case (sel)
         BYP_MEM: out_val = mem_val;
         BYP_WB:  out_val = wb_val;
         default: out_val = rf_val;
      endcase
   end

endmodule

// File: rtl/opbyp_top.sv
module opbyp_top
   import opbyp_pkg::*;
#(
   parameter int unsigned REG_IDX_W  = 5,
   parameter int unsigned DATA_W     = 32,
   parameter bit          ZERO_GUARD = 1'b1
) (
   input  logic [REG_IDX_W-1:0] ex_src1_idx,
   input  logic [REG_IDX_W-1:0] ex_src2_idx,
   input  logic [DATA_W-1:0]    ex_src1_val,
   input  logic [DATA_W-1:0]    ex_src2_val,
   input  logic [REG_IDX_W-1:0] mem_dst_idx,
   input  logic                 mem_wr_en,
   input  logic [DATA_W-1:0]    mem_result,
   input  logic [REG_IDX_W-1:0] wb_dst_idx,
   input  logic                 wb_wr_en,
   input  logic [DATA_W-1:0]    wb_result,
   output logic [1:0]           sel_a,
   output logic [1:0]           sel_b,
   output logic [DATA_W-1:0]    alu_in_a,
   output logic [DATA_W-1:0]    alu_in_b
);

   localparam int unsigned NOPS = NUM_OPERANDS;

   generate
      if (REG_IDX_W < 1 || REG_IDX_W > 8) begin : g_bad_idx_w
         $error("opbyp_top: REG_IDX_W must lie in 1..8");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("opbyp_top: DATA_W must be at least 1");
      end
   endgenerate

   logic [REG_IDX_W-1:0] src_idx [NOPS];
   logic [DATA_W-1:0]    src_val [NOPS];
   byp_sel_e             sel     [NOPS];
   logic [DATA_W-1:0]    op_val  [NOPS];

   assign src_idx[0] = ex_src1_idx;
   assign src_idx[1] = ex_src2_idx;
   assign src_val[0] = ex_src1_val;
   assign src_val[1] = ex_src2_val;

   for (genvar op = 0; op < NOPS; op++) begin : g_operand
      logic hit_mem;
      logic hit_wb;

      opbyp_match #(
         .REG_IDX_W  (REG_IDX_W),
         .ZERO_GUARD (ZERO_GUARD)
      ) u_match_mem (
         .src_idx (src_idx[op]),
         .dst_idx (mem_dst_idx),
         .wr_en   (mem_wr_en),
         .hit     (hit_mem)
      );

      opbyp_match #(
         .REG_IDX_W  (REG_IDX_W),
         .ZERO_GUARD (ZERO_GUARD)
      ) u_match_wb (
         .src_idx (src_idx[op]),
         .dst_idx (wb_dst_idx),
         .wr_en   (wb_wr_en),
         .hit     (hit_wb)
      );

      opbyp_prio u_prio (
         .hit_mem (hit_mem),
         .hit_wb  (hit_wb),
         .sel     (sel[op])
      );

      opbyp_mux #(
         .DATA_W (DATA_W)
      ) u_mux (
         .sel     (sel[op]),
         .rf_val  (src_val[op]),
         .mem_val (mem_result),
         .wb_val  (wb_result),
         .out_val (op_val[op])
      );
   end

   assign sel_a    = sel[0];
   assign sel_b    = sel[1];
   assign alu_in_a = op_val[0];
   assign alu_in_b = op_val[1];

endmodule

// File: rtl/opbyp_checker.sv
module opbyp_checker #(
   parameter int unsigned REG_IDX_W = 5,
   parameter int unsigned DATA_W    = 32
) (
   input logic [REG_IDX_W-1:0] ex_src1_idx,
   input logic [REG_IDX_W-1:0] ex_src2_idx,
   input logic [DATA_W-1:0]    ex_src1_val,
   input logic [DATA_W-1:0]    ex_src2_val,
   input logic [REG_IDX_W-1:0] mem_dst_idx,
   input logic                 mem_wr_en,
   input logic [DATA_W-1:0]    mem_result,
   input logic [REG_IDX_W-1:0] wb_dst_idx,
   input logic                 wb_wr_en,
   input logic [DATA_W-1:0]    wb_result,
   input logic [1:0]           sel_a,
   input logic [1:0]           sel_b,
   input logic [DATA_W-1:0]    alu_in_a,
   input logic [DATA_W-1:0]    alu_in_b
);

   logic known;
   assign known = !$isunknown({ex_src1_idx, ex_src2_idx, mem_dst_idx, mem_wr_en,
                               wb_dst_idx, wb_wr_en, sel_a, sel_b});

   always_comb begin
      if (known) begin
         // R8: the unused code never appears
         a_r8_sel_legal: assert (sel_a != 2'b11 && sel_b != 2'b11);
         // R5: no writer in flight means no bypass
         a_r5_no_writer: assert ((mem_wr_en || wb_wr_en) || (sel_a == 2'b00 && sel_b == 2'b00));
         // R6: both destinations zero means no bypass
         a_r6_zero_dst: assert ((mem_dst_idx != '0 || wb_dst_idx != '0) ||
                                (sel_a == 2'b00 && sel_b == 2'b00));
         // R4: double match on operand A resolves to the younger stage
         a_r4_prio_a: assert (!(mem_wr_en && wb_wr_en && mem_dst_idx != '0 &&
                                mem_dst_idx == ex_src1_idx && wb_dst_idx == ex_src1_idx) ||
                              sel_a == 2'b10);
         // R1: register-file select passes the register value for both operands
         a_r1_rf_pass: assert ((sel_a != 2'b00 || alu_in_a === ex_src1_val) &&
                               (sel_b != 2'b00 || alu_in_b === ex_src2_val));
         // R2, R3: bypass selects route the matching stage's result
         a_r2_mem_route: assert ((sel_a != 2'b10 || alu_in_a === mem_result) &&
                                 (sel_b != 2'b10 || alu_in_b === mem_result));
         a_r3_wb_route: assert ((sel_a != 2'b01 || alu_in_a === wb_result) &&
                                (sel_b != 2'b01 || alu_in_b === wb_result));
      end
   end

endmodule

bind opbyp_top opbyp_checker #(
   .REG_IDX_W (REG_IDX_W),
   .DATA_W    (DATA_W)
) u_opbyp_checker (.*);

// File: tb/opbyp_top_bench.sv
module opbyp_top_bench;

   localparam int unsigned IW = 5;
   localparam int unsigned DW = 32;

   localparam logic [DW-1:0] V_SRC1 = 32'hA1A1_0001;
   localparam logic [DW-1:0] V_SRC2 = 32'hB2B2_0002;
   localparam logic [DW-1:0] V_MEM  = 32'hC3C3_0003;
   localparam logic [DW-1:0] V_WB   = 32'hD4D4_0004;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic [IW-1:0] ex_src1_idx, ex_src2_idx, mem_dst_idx, wb_dst_idx;
   logic [DW-1:0] ex_src1_val, ex_src2_val, mem_result, wb_result;
   logic          mem_wr_en, wb_wr_en;
   logic [1:0]    sel_a, sel_b;
   logic [DW-1:0] alu_in_a, alu_in_b;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   opbyp_top #(.REG_IDX_W(IW), .DATA_W(DW)) u_opbyp_top (
      .ex_src1_idx (ex_src1_idx), .ex_src2_idx (ex_src2_idx),
      .ex_src1_val (ex_src1_val), .ex_src2_val (ex_src2_val),
      .mem_dst_idx (mem_dst_idx), .mem_wr_en (mem_wr_en), .mem_result (mem_result),
      .wb_dst_idx  (wb_dst_idx),  .wb_wr_en  (wb_wr_en),  .wb_result  (wb_result),
      .sel_a (sel_a), .sel_b (sel_b), .alu_in_a (alu_in_a), .alu_in_b (alu_in_b)
   );

   // Expected steering code from the requirements
   function automatic logic [1:0] exp_sel(input logic [IW-1:0] src);
      bit mh, wh;
      mh = mem_wr_en && (mem_dst_idx != 0) && (mem_dst_idx == src);
      wh = wb_wr_en  && (wb_dst_idx  != 0) && (wb_dst_idx  == src);
      if (mh)      return 2'b10;
      else if (wh) return 2'b01;
      else         return 2'b00;
   endfunction

   function automatic logic [DW-1:0] exp_val(input logic [1:0] s, input logic [DW-1:0] rf);
      case (s)
         2'b10:   return V_MEM;
         2'b01:   return V_WB;
         default: return rf;
      endcase
   endfunction

   task automatic chk(input string req, input string what, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Drive at the falling edge, sample 1 ns later: well away from the rising edge
   task automatic apply(input logic [IW-1:0] s1, input logic [IW-1:0] s2,
                        input logic [IW-1:0] md, input logic me,
                        input logic [IW-1:0] wd, input logic we);
      @(negedge clk);
      ex_src1_idx = s1; ex_src2_idx = s2;
      mem_dst_idx = md; mem_wr_en = me;
      wb_dst_idx  = wd; wb_wr_en  = we;
      #1;
   endtask

   task automatic chk_all(input string req);
      logic [1:0] ea, eb;
      ea = exp_sel(ex_src1_idx);
      eb = exp_sel(ex_src2_idx);
      chk(req, "sel_a", {30'd0, sel_a}, {30'd0, ea});
      chk(req, "sel_b", {30'd0, sel_b}, {30'd0, eb});
      chk(req, "alu_in_a", alu_in_a, exp_val(ea, V_SRC1));
      chk(req, "alu_in_b", alu_in_b, exp_val(eb, V_SRC2));
   endtask

   task automatic t_idle_state;
      apply(5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0);
      chk("R1", "idle sel_a", {30'd0, sel_a}, 32'd0);
      chk("R1", "idle alu_in_a", alu_in_a, V_SRC1);
      chk("R1", "idle alu_in_b", alu_in_b, V_SRC2);
   endtask

   task automatic t_no_match;
      apply(5'd3, 5'd4, 5'd7, 1'b1, 5'd9, 1'b1);
      chk("R1", "sel_a", {30'd0, sel_a}, 32'd0);
      chk("R1", "sel_b", {30'd0, sel_b}, 32'd0);
      chk_all("R1");
   endtask

   task automatic t_mem_fwd;
      apply(5'd6, 5'd2, 5'd6, 1'b1, 5'd11, 1'b1);
      chk("R2", "sel_a", {30'd0, sel_a}, 32'd2);
      chk("R2", "alu_in_a", alu_in_a, V_MEM);
      apply(5'd2, 5'd6, 5'd6, 1'b1, 5'd11, 1'b1);
      chk("R2", "sel_b", {30'd0, sel_b}, 32'd2);
      chk("R2", "alu_in_b", alu_in_b, V_MEM);
   endtask

   task automatic t_wb_fwd;
      apply(5'd8, 5'd1, 5'd12, 1'b1, 5'd8, 1'b1);
      chk("R3", "sel_a", {30'd0, sel_a}, 32'd1);
      chk("R3", "alu_in_a", alu_in_a, V_WB);
      apply(5'd1, 5'd8, 5'd12, 1'b1, 5'd8, 1'b1);
      chk("R3", "sel_b", {30'd0, sel_b}, 32'd1);
      chk("R3", "alu_in_b", alu_in_b, V_WB);
   endtask

   task automatic t_priority;
      apply(5'd10, 5'd10, 5'd10, 1'b1, 5'd10, 1'b1);
      chk("R4", "sel_a", {30'd0, sel_a}, 32'd2);
      chk("R4", "sel_b", {30'd0, sel_b}, 32'd2);
      chk("R4", "alu_in_a", alu_in_a, V_MEM);
      // younger stage drops out: older one takes over
      apply(5'd10, 5'd10, 5'd10, 1'b0, 5'd10, 1'b1);
      chk("R4", "fallback sel_a", {30'd0, sel_a}, 32'd1);
   endtask

   task automatic t_wr_disabled;
      apply(5'd5, 5'd5, 5'd5, 1'b0, 5'd5, 1'b0);
      chk("R5", "sel_a", {30'd0, sel_a}, 32'd0);
      chk("R5", "alu_in_b", alu_in_b, V_SRC2);
      apply(5'd5, 5'd13, 5'd13, 1'b0, 5'd5, 1'b0);
      chk("R5", "mixed sel_a", {30'd0, sel_a}, 32'd0);
      chk("R5", "mixed sel_b", {30'd0, sel_b}, 32'd0);
   endtask

   task automatic t_zero_reg;
      apply(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1);
      chk("R6", "sel_a", {30'd0, sel_a}, 32'd0);
      chk("R6", "sel_b", {30'd0, sel_b}, 32'd0);
      chk("R6", "alu_in_a", alu_in_a, V_SRC1);
      // zero in the memory stage must not hide a real writeback match
      apply(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1);
      apply(5'd0, 5'd14, 5'd0, 1'b1, 5'd14, 1'b1);
      chk("R6", "src2 from wb", {30'd0, sel_b}, 32'd1);
   endtask

   task automatic t_independent;
      apply(5'd17, 5'd19, 5'd17, 1'b1, 5'd19, 1'b1);
      chk("R7", "sel_a", {30'd0, sel_a}, 32'd2);
      chk("R7", "sel_b", {30'd0, sel_b}, 32'd1);
      chk("R7", "alu_in_a", alu_in_a, V_MEM);
      chk("R7", "alu_in_b", alu_in_b, V_WB);
      apply(5'd19, 5'd17, 5'd17, 1'b1, 5'd19, 1'b1);
      chk("R7", "swapped sel_a", {30'd0, sel_a}, 32'd1);
      chk("R7", "swapped sel_b", {30'd0, sel_b}, 32'd2);
   endtask

   task automatic t_sweep;
      for (int s1 = 0; s1 < 3; s1++)
         for (int s2 = 0; s2 < 3; s2++)
            for (int md = 0; md < 3; md++)
               for (int wd = 0; wd < 3; wd++)
                  for (int en = 0; en < 4; en++) begin
                     apply(IW'(s1), IW'(s2), IW'(md), en[0], IW'(wd), en[1]);
                     chk("R8", "sel_a legal", {31'd0, sel_a == 2'b11}, 32'd0);
                     chk_all("R7");
                  end
   endtask

   task automatic t_no_clock;
      // change inputs mid-phase without any edge and look 1 ns later
      @(posedge clk);
      #1;
      ex_src1_idx = 5'd21; mem_dst_idx = 5'd21; mem_wr_en = 1'b1;
      #1;
      chk("R9", "sel_a", {30'd0, sel_a}, 32'd2);
      mem_wr_en = 1'b0;
      #1;
      chk("R9", "sel_a release", {30'd0, sel_a}, 32'd0);
   endtask

   initial begin
      ex_src1_val = V_SRC1; ex_src2_val = V_SRC2;
      mem_result  = V_MEM;  wb_result   = V_WB;
      t_idle_state();
      t_no_match();
      t_mem_fwd();
      t_wb_fwd();
      t_priority();
      t_wr_disabled();
      t_zero_reg();
      t_independent();
      t_sweep();
      t_no_clock();
      if (!finished) begin
         finished = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

endmodule